// File: doc/BRIEF.md
# Bidirectional GPIO Port with Key Wake-Up Interrupt

This block is an eight-pin general-purpose port for a small microcontroller. Each pin has three control bits: a direction bit, an output latch bit and a pull-up enable bit. A pin whose direction bit is 1 drives its latch value onto the pad. A pin whose direction bit is 0 is an input. The pad level of an input pin passes through a two-flop synchronizer before any logic uses it.

The port also raises a wake-up interrupt for an active-low key matrix. A common arrangement drives the top three pins low as matrix columns and reads the lower five pins as rows with pull-ups enabled. In that arrangement, pressing any key pulls one row low.

The block combines every input-mode pin into one AND term. A pin in output mode is forced to 1 inside that term, so it never takes part. A high-to-low change of the AND term sets a sticky flag, and the flag drives the interrupt request.

Software uses a plain register interface:
- It writes the latch, direction and pull-up registers.
- It reads the port, or any of those registers, back.
- It clears the flag by writing 1 to it.

Top module: `kwu_gpio_port`

## Requirements
- R1: The direction register (address 1) resets to 0 and drives `pad_oe_o` bit for bit. A 1 makes the pin an output.
- R2: The latch register (address 0 on write) resets to 0 and drives `pad_out_o` bit for bit.
- R3: `pad_pu_o[i]` is 1 only when pull-up bit i (address 2) is 1 and pin i is in input mode.
- R4: A read of address 0 returns, for each pin, the latch bit if the pin is an output. If the pin is an input, it returns the pad level after two clock edges of synchronization.
- R5: Reads of addresses 1 and 2 return the direction and pull-up registers. A read of address 3 returns the flag in bit 0 and zeros in bits 7..1.
- R6: The flag is set one edge after the AND of synchronized input-mode pin levels falls from 1 to 0. The flag stays set, and `key_irq_o` equals the flag. A pad going low therefore raises `key_irq_o` on the third rising edge after the change.
- R7: Pins in output mode do not take part in the AND term. A low level on an output pin's pad never sets the flag.
- R8: Writing address 3 with bit 0 = 1 clears the flag. If a falling edge is detected in the same cycle, the flag stays set.
- R9: After reset the flag is clear and the AND history starts at 1. An input pin that is already low after reset produces exactly one request.
- R10: A direction write that makes the AND term fall, for example turning a low output pin into an input, sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 port/latch, 1 direction, 2 pull-up, 3 flag |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` (combinational) |
| pad_in_i | input | 8 | Pad input levels (asynchronous) |
| pad_oe_o | output | 8 | Pad output enables |
| pad_out_o | output | 8 | Pad output data |
| pad_pu_o | output | 8 | Pad pull-up enables |
| key_irq_o | output | 1 | Key wake-up interrupt request |

## Verification
The bench releases reset with one pin already low. A design whose history register starts at 0, or whose synchronizer resets low, either misses that request or raises a false one.

It drives output pins low while the inputs stay high. A design that ignores the direction gate would wake on its own column drives.

It issues a flag clear in exactly the cycle a new edge is detected. A design that lets the clear win drops that key press.

It turns a low output pin into an input. A design that watches only pad changes would miss that wake-up. Random register traffic and pad activity are then compared cycle by cycle against a behavioural model.

// File: rtl/kwu_pkg.sv
package kwu_pkg;
  typedef enum logic [1:0] {
    REG_PORT = 2'd0,
    REG_DIR  = 2'd1,
    REG_PULL = 2'd2,
    REG_FLAG = 2'd3
  } kwu_reg_e;
endpackage

// File: rtl/kwu_sync.sv
module kwu_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (g == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stage_q[g-1];
    end
    // reset high: idle level of a pulled-up key row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= '1;
      else         stage_q[g] <= src;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/kwu_port_regs.sv
module kwu_port_regs
  import kwu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  kwu_reg_e         addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] latch_o,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] pull_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o <= '0;
      dir_o   <= '0;
      pull_o  <= '0;
    end else if (we_i) begin
      case (addr_i)
        REG_PORT: latch_o <= wdata_i;
        REG_DIR:  dir_o   <= wdata_i;
        REG_PULL: pull_o  <= wdata_i;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/kwu_wake_detect.sv
module kwu_wake_detect #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic             clr_i,
  output logic             fall_o,
  output logic             flag_o
);
  logic and_now, and_q;

  // output-mode pins forced to 1 so they never pull the term low
  assign and_now = &(lvl_i | dir_i);
  assign fall_o  = and_q & ~and_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      and_q  <= 1'b1;
      flag_o <= 1'b0;
    end else begin
      and_q <= and_now;
      if (fall_o)     flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/kwu_gpio_port.sv
module kwu_gpio_port
  import kwu_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_we_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [WIDTH-1:0] bus_wdata_i,
  output logic [WIDTH-1:0] bus_rdata_o,
  input  logic [WIDTH-1:0] pad_in_i,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_pu_o,
  output logic             key_irq_o
);
  kwu_reg_e         addr;
  logic [WIDTH-1:0] latch_q, dir_q, pull_q, lvl_sync;
  logic             flag_clr, key_fall, flag_q;

  assign addr = kwu_reg_e'(bus_addr_i);

  kwu_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(lvl_sync)
  );

  kwu_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i, .rst_ni, .we_i(bus_we_i), .addr_i(addr), .wdata_i(bus_wdata_i),
    .latch_o(latch_q), .dir_o(dir_q), .pull_o(pull_q)
  );

  assign flag_clr = bus_we_i && (addr == REG_FLAG) && bus_wdata_i[0];

  kwu_wake_detect #(.WIDTH(WIDTH)) u_wake (
    .clk_i, .rst_ni, .lvl_i(lvl_sync), .dir_i(dir_q), .clr_i(flag_clr),
    .fall_o(key_fall), .flag_o(flag_q)
  );

  assign pad_oe_o  = dir_q;
  assign pad_out_o = latch_q;
  assign pad_pu_o  = pull_q & ~dir_q;
  assign key_irq_o = flag_q;

  always_comb begin
    case (addr)
      REG_PORT: bus_rdata_o = (latch_q & dir_q) | (lvl_sync & ~dir_q);
      REG_DIR:  bus_rdata_o = dir_q;
      REG_PULL: bus_rdata_o = pull_q;
      default:  bus_rdata_o = {{(WIDTH-1){1'b0}}, flag_q};
    endcase
  end
endmodule

// File: rtl/kwu_gpio_port_chk.sv
module kwu_gpio_port_chk
  import kwu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_we_i,
  input logic [1:0]       bus_addr_i,
  input logic             clr_bit_i,
  input logic [WIDTH-1:0] pad_oe_o,
  input logic [WIDTH-1:0] pad_pu_o,
  input logic             key_irq_o,
  input logic             key_fall
);
  logic dir_wr, clr_wr;
  assign dir_wr = bus_we_i && (bus_addr_i == 2'(REG_DIR));
  assign clr_wr = bus_we_i && (bus_addr_i == 2'(REG_FLAG)) && clr_bit_i;

  AST_PU_INPUT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pu_o & pad_oe_o) == '0); // R3
  AST_OE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_wr |=> $stable(pad_oe_o)); // R1
  AST_FALL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_fall |=> key_irq_o); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_irq_o && !clr_wr |=> key_irq_o); // R6
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr && !key_fall |=> !key_irq_o); // R8
  AST_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(key_irq_o) |-> $past(key_fall)); // R7
endmodule

bind kwu_gpio_port kwu_gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
  .clr_bit_i(bus_wdata_i[0]), .pad_oe_o(pad_oe_o), .pad_pu_o(pad_pu_o),
  .key_irq_o(key_irq_o), .key_fall(key_fall)
);

// File: tb/kwu_gpio_port_tb.sv
module kwu_gpio_port_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = '0, pad = 8'hFE;
  logic [7:0] rdata, oe, pout, pu;
  logic       irq;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  // reference model state
  logic [7:0] m_lat, m_dir, m_pull, m_s1, m_s2;
  logic       m_andq, m_flag;

  always #(CLK_P/2) clk = ~clk;

  kwu_gpio_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pad_in_i(pad),
    .pad_oe_o(oe), .pad_out_o(pout), .pad_pu_o(pu), .key_irq_o(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lat = '0; m_dir = '0; m_pull = '0; m_s1 = '1; m_s2 = '1;
      m_andq = 1'b1; m_flag = 1'b0;
    end else begin
      logic a_now, fall, clr;
      a_now = &(m_s2 | m_dir);
      fall  = m_andq && !a_now;
      clr   = we && addr == 2'd3 && wdata[0];
      if (fall) m_flag = 1'b1;
      else if (clr) m_flag = 1'b0;
      m_andq = a_now;
      m_s2 = m_s1;
      m_s1 = pad;
      if (we) begin
        if (addr == 2'd0) m_lat = wdata;
        if (addr == 2'd1) m_dir = wdata;
        if (addr == 2'd2) m_pull = wdata;
      end
    end
  end

  // compare every cycle, a quarter period after the rising edge
  always begin
    @(posedge clk);
    #(CLK_P/4);
    if (rst_n && !done) begin
      logic [7:0] exp_rd;
      case (addr)
        2'd0:    exp_rd = (m_lat & m_dir) | (m_s2 & ~m_dir);
        2'd1:    exp_rd = m_dir;
        2'd2:    exp_rd = m_pull;
        default: exp_rd = {7'b0, m_flag};
      endcase
      chk("R1 pad_oe", oe, m_dir);
      chk("R2 pad_out", pout, m_lat);
      chk("R3 pad_pu", pu, m_pull & ~m_dir);
      chk(addr == 2'd0 ? "R4 port read" : "R5 reg read", rdata, exp_rd);
      chk("R6 R8 irq", {7'b0, irq}, {7'b0, m_flag});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 2);
    chk("R9 reset oe", oe, 8'h00);
    chk("R9 reset out", pout, 8'h00);
    chk("R9 reset pu", pu, 8'h00);
    chk("R9 reset irq", {7'b0, irq}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    idle(5);
    chk("R9 low pin after reset requests", {7'b0, irq}, 8'h01);
    wr(2'd3, 8'h01); idle(4);
    chk("R9 single request only", {7'b0, irq}, 8'h00);

    // key matrix: upper pins output low, lower inputs with pull-ups
    pad = 8'h1F;
    wr(2'd0, 8'h00); wr(2'd1, 8'hE0); wr(2'd2, 8'h1F);
    idle(4); wr(2'd3, 8'h01); idle(4);
    chk("R7 output pins excluded", {7'b0, irq}, 8'h00);
    addr = 2'd0; @(negedge clk);
    chk("R4 port read mix", rdata, 8'h1F);
    pad = 8'h1B; idle(4);
    chk("R6 key press", {7'b0, irq}, 8'h01);
    addr = 2'd2; @(negedge clk);
    chk("R5 pull read", rdata, 8'h1F);

    // clear in the same cycle as a new edge: edge wins
    pad = 8'h1F; idle(4); wr(2'd3, 8'h01); idle(2);
    chk("R8 cleared", {7'b0, irq}, 8'h00);
    @(negedge clk); pad = 8'h17;
    @(negedge clk);
    wr(2'd3, 8'h01);
    chk("R8 edge beats clear", {7'b0, irq}, 8'h01);
    wr(2'd3, 8'h01); @(negedge clk);
    chk("R8 plain clear", {7'b0, irq}, 8'h00);

    // direction change exposes a low pin
    pad = 8'h7F; idle(4); wr(2'd3, 8'h01); idle(3);
    chk("R10 still clear", {7'b0, irq}, 8'h00);
    wr(2'd1, 8'h60); @(negedge clk);
    chk("R10 dir change sets flag", {7'b0, irq}, 8'h01);

    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      we = ($urandom_range(3) == 0);
      addr = 2'($urandom_range(3));
      wdata = 8'($urandom);
      if ($urandom_range(4) == 0) pad = 8'($urandom) | 8'($urandom);
    end
    @(negedge clk); we = 1'b0;
    idle(4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule